// File: doc/BRIEF.md
# Clock-Detect Power-Up Sequencer

This block brings a converter core out of power-down in a fixed order. After reset it holds the interpolation and modulator pipelines in reset with every power enable off. It then waits for both the master clock and the frame (left/right) clock to toggle. Once both are running, it counts master-clock rising edges over one frame period. It rounds that count to a supported master-to-frame ratio. It then turns on the voltage reference and waits a programmable settle time. Next it enables the converters and output filters, releasing the core reset, and issues a one-cycle strobe that starts the analog output ramp. A ready flag follows the strobe.

All logic runs on a free-running supervisory clock. Both monitored clocks are treated as data: each passes through a synchronizer and edge detector. Each has its own watchdog counter, and a clock with no edge for `TIMEOUT` supervisory cycles is judged absent. The loss of either clock, or an assertion of reset, sends the block back to power-down from any state. The supervisory clock must run more than twice as fast as the master clock.

Top module: `pwrseq_top`

## Requirements
- R1: While `rstN` is low and in the first cycle after its release, `coreRst` is 1, `refEn`, `convEn`, `rampStart` and `ready` are 0, and `ratio` is 0.
- R2: With only one of the two monitored clocks toggling, the block stays in power-down: `refEn` stays 0 and `coreRst` stays 1.
- R3: Once both clocks run, the block counts master-clock rising edges between two consecutive falling edges of `frameClk`. A count within ±`TOL` (default 16) of 128, 192, 256, 384 or 512 is rounded to that value. The rounded value appears on `ratio` as a plain binary number by the time `refEn` rises, and `ratio` is 0 whenever `refEn` is 0.
- R4: A count that lies within tolerance of no supported value keeps the block measuring frame after frame. In that case `refEn` stays 0, `coreRst` stays 1 and `ratio` stays 0.
- R5: `refEn` rises first. `convEn` rises exactly `settleCycles`+1 supervisory cycles later. `coreRst` falls in the same cycle that `convEn` rises, and `convEn` is never 1 without `refEn`.
- R6: `rampStart` is 1 for exactly the one cycle in which `convEn` rises. `ready` rises in the next cycle and stays high.
- R7: If either monitored clock shows no edge for `TIMEOUT` supervisory cycles, the block returns to the R1 output state within a few cycles, whatever state it was in.
- R8: Driving `rstN` low forces the R1 output state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running supervisory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterClk | input | 1 | Monitored master clock, sampled as data |
| frameClk | input | 1 | Monitored frame (left/right) clock, sampled as data |
| settleCycles | input | SETTLE_W | Reference settle delay in supervisory cycles |
| coreRst | output | 1 | Holds interpolation and modulator pipelines in reset |
| refEn | output | 1 | Voltage reference power enable |
| convEn | output | 1 | Converter and output filter power enable |
| rampStart | output | 1 | One-cycle strobe that starts the output ramp |
| ready | output | 1 | Start-up sequence complete |
| ratio | output | RATIO_W | Measured master-to-frame clock ratio |

## Verification
Every supported ratio is driven as an exact frame period. An off-nominal period of 250 master clocks is also driven, to show that rounding picks the nearest value rather than requiring an exact match. A period of 320, which lies between two supported values, must leave the block measuring with no enables. This separates a tolerance window from plain nearest-value rounding. Runs with only one clock toggling, a lost master clock in the powered state, and reset asserted mid-sequence confirm that both clocks gate start-up and that any fault unwinds every enable. The settle delay is varied between cases, so that an off-by-one in the reference-to-converter gap shows up.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_MEAS = 3'd1,
    PS_REF  = 3'd2,
    PS_CONV = 3'd3,
    PS_ON   = 3'd4
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic measClr;
    logic settleClr;
    logic latchRatio;
    logic ratioClr;
  } seqStrobes_t;

  // datapath -> control status
  typedef struct packed {
    logic clocksOk;
    logic measDone;
    logic settleDone;
  } dpStatus_t;

  localparam int N_RATIOS = 5;
  localparam int RATIO_LIST [N_RATIOS] = '{128, 192, 256, 384, 512};
  localparam int MAX_RATIO = 512;

endpackage

// File: rtl/pwrseq_datapath.sv
module pwrseq_datapath
  import pwrseq_pkg::*;
#(
  parameter int TIMEOUT     = 2048,
  parameter int SYNC_STAGES = 2,
  parameter int TOL         = 16,
  parameter int SETTLE_W    = 8,
  parameter int CNT_W       = $clog2(MAX_RATIO * 4),
  parameter int RATIO_W     = $clog2(MAX_RATIO + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterClk,
  input  logic                frameClk,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  seqStrobes_t         stb,
  output dpStatus_t           sts,
  output logic [RATIO_W-1:0]  ratio
);

  localparam int TO_W = $clog2(TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_MAX = TO_W'(TIMEOUT);

  // synchronizers and edge detection, index 0 = master, 1 = frame
  logic [1:0] rawIn;
  logic [1:0] nowLvl;
  logic [1:0] prevLvl;
  logic [1:0] toggled;
  logic [1:0] alive;

  assign rawIn = {frameClk, masterClk};

  for (genvar g = 0; g < 2; g++) begin : g_mon
    logic [SYNC_STAGES-1:0] syncChain;
    logic [TO_W-1:0]        wdCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain  <= '0;
        prevLvl[g] <= 1'b0;
      end else begin
        syncChain  <= {syncChain[SYNC_STAGES-2:0], rawIn[g]};
        prevLvl[g] <= syncChain[SYNC_STAGES-1];
      end
    end

    assign nowLvl[g]  = syncChain[SYNC_STAGES-1];
    assign toggled[g] = nowLvl[g] ^ prevLvl[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                wdCnt <= TO_MAX;
      else if (toggled[g])      wdCnt <= '0;
      else if (wdCnt != TO_MAX) wdCnt <= wdCnt + 1'b1;
    end

    assign alive[g] = (wdCnt != TO_MAX);
  end

  logic mRise;
  logic fFall;
  assign mRise = nowLvl[0] & ~prevLvl[0];
  assign fFall = ~nowLvl[1] & prevLvl[1];

  // ratio measurement: master rising edges between frame falling edges
  logic [CNT_W-1:0] measCnt;
  logic             armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measCnt <= '0;
      armed   <= 1'b0;
    end else if (stb.measClr) begin
      measCnt <= '0;
      armed   <= 1'b0;
    end else if (fFall) begin
      armed   <= 1'b1;
      measCnt <= CNT_W'(mRise);
    end else if (mRise && (measCnt != '1)) begin
      measCnt <= measCnt + 1'b1;
    end
  end

  // round to nearest supported ratio within tolerance
  logic               hit;
  logic [RATIO_W-1:0] rounded;

  always_comb begin
    int c;
    c       = int'(measCnt);
    hit     = 1'b0;
    rounded = '0;
    for (int k = 0; k < N_RATIOS; k++) begin
      if ((c + TOL >= RATIO_LIST[k]) && (c <= RATIO_LIST[k] + TOL)) begin
        hit     = 1'b1;
        rounded = RATIO_W'(RATIO_LIST[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ratio <= '0;
    else if (stb.ratioClr)   ratio <= '0;
    else if (stb.latchRatio) ratio <= rounded;
  end

  // reference settle counter
  logic [SETTLE_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  settleCnt <= '0;
    else if (stb.settleClr)     settleCnt <= '0;
    else if (settleCnt != '1)   settleCnt <= settleCnt + 1'b1;
  end

  assign sts.clocksOk   = &alive;
  assign sts.measDone   = fFall & armed & hit;
  assign sts.settleDone = (settleCnt == settleCycles);

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   sts,
  output seqStrobes_t stb,
  output logic        coreRst,
  output logic        refEn,
  output logic        convEn,
  output logic        rampStart,
  output logic        ready
);

  seqState_t state;
  seqState_t nextState;

  always_comb begin
    nextState = state;
    if (!sts.clocksOk) begin
      nextState = PS_OFF;
    end else begin
      unique case (state)
        PS_OFF:  nextState = PS_MEAS;
        PS_MEAS: if (sts.measDone)   nextState = PS_REF;
        PS_REF:  if (sts.settleDone) nextState = PS_CONV;
        PS_CONV: nextState = PS_ON;
        PS_ON:   nextState = PS_ON;
        default: nextState = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_OFF;
    else       state <= nextState;
  end

  always_comb begin
    stb.measClr    = (state != PS_MEAS);
    stb.settleClr  = (state != PS_REF);
    stb.latchRatio = (state == PS_MEAS) && sts.measDone;
    stb.ratioClr   = !sts.clocksOk || (state == PS_OFF);
  end

  assign refEn     = (state == PS_REF) || (state == PS_CONV) || (state == PS_ON);
  assign convEn    = (state == PS_CONV) || (state == PS_ON);
  assign coreRst   = !convEn;
  assign rampStart = (state == PS_CONV);
  assign ready     = (state == PS_ON);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int TIMEOUT     = 2048,
  parameter int SYNC_STAGES = 2,
  parameter int TOL         = 16,
  parameter int SETTLE_W    = 8,
  parameter int RATIO_W     = $clog2(MAX_RATIO + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterClk,
  input  logic                frameClk,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                coreRst,
  output logic                refEn,
  output logic                convEn,
  output logic                rampStart,
  output logic                ready,
  output logic [RATIO_W-1:0]  ratio
);

  seqStrobes_t stb;
  dpStatus_t   sts;

  pwrseq_datapath #(
    .TIMEOUT    (TIMEOUT),
    .SYNC_STAGES(SYNC_STAGES),
    .TOL        (TOL),
    .SETTLE_W   (SETTLE_W),
    .RATIO_W    (RATIO_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .masterClk   (masterClk),
    .frameClk    (frameClk),
    .settleCycles(settleCycles),
    .stb         (stb),
    .sts         (sts),
    .ratio       (ratio)
  );

  pwrseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sts      (sts),
    .stb      (stb),
    .coreRst  (coreRst),
    .refEn    (refEn),
    .convEn   (convEn),
    .rampStart(rampStart),
    .ready    (ready)
  );

endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
  parameter int RATIO_W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               coreRst,
  input logic               refEn,
  input logic               convEn,
  input logic               rampStart,
  input logic               ready,
  input logic [RATIO_W-1:0] ratio
);

  assert_conv_needs_ref_R5: assert property (@(posedge clk) disable iff (!rstN)
    convEn |-> refEn);

  assert_ref_before_conv_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convEn) |-> $past(refEn));

  assert_core_rst_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    !coreRst |-> convEn);

  assert_ratio_supported_R3: assert property (@(posedge clk) disable iff (!rstN)
    refEn |-> (ratio == 128 || ratio == 192 || ratio == 256 ||
               ratio == 384 || ratio == 512));

  assert_ratio_idle_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !refEn |-> (ratio == '0));

  assert_ramp_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rampStart |=> (!rampStart && ready));

  assert_ready_after_ramp_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(rampStart));

endmodule

bind pwrseq_top pwrseq_checker #(.RATIO_W(RATIO_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .coreRst  (coreRst),
  .refEn    (refEn),
  .convEn   (convEn),
  .rampStart(rampStart),
  .ready    (ready),
  .ratio    (ratio)
);

// File: tb/pwrseq_top_tb.sv
`timescale 1ns/1ps
module pwrseq_top_tb;

  localparam int TIMEOUT  = 2048;
  localparam int SETTLE_W = 8;
  localparam int RATIO_W  = 10;
  localparam int NVEC     = 6;
  localparam int VEC_RATIO  [NVEC] = '{128, 192, 256, 384, 512, 250};
  localparam int VEC_SETTLE [NVEC] = '{0,   5,   20,  1,   63,  7};
  localparam int VEC_EXP    [NVEC] = '{128, 192, 256, 384, 512, 256};

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                masterClk = 1'b0;
  logic                frameClk = 1'b0;
  logic [SETTLE_W-1:0] settleCycles = '0;
  logic                coreRst, refEn, convEn, rampStart, ready;
  logic [RATIO_W-1:0]  ratio;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  bit mRun = 0;
  bit fRun = 0;
  int fHalf = 256;
  int mDiv = 0;
  int fDiv = 0;

  always #10 clk = ~clk;

  pwrseq_top #(.TIMEOUT(TIMEOUT), .SETTLE_W(SETTLE_W), .RATIO_W(RATIO_W)) u_dut (
    .clk(clk), .rstN(rstN), .masterClk(masterClk), .frameClk(frameClk),
    .settleCycles(settleCycles), .coreRst(coreRst), .refEn(refEn),
    .convEn(convEn), .rampStart(rampStart), .ready(ready), .ratio(ratio)
  );

  // master clock: period 4 supervisory cycles; frame clock: half period fHalf
  always @(negedge clk) begin
    if (mRun) begin
      if (mDiv == 1) begin mDiv <= 0; masterClk <= ~masterClk; end
      else mDiv <= mDiv + 1;
    end
    if (fRun) begin
      if (fDiv >= fHalf - 1) begin fDiv <= 0; frameClk <= ~frameClk; end
      else fDiv <= fDiv + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOff(input string tag);
    check(coreRst == 1'b1 && refEn == 1'b0 && convEn == 1'b0 &&
          rampStart == 1'b0 && ready == 1'b0 && ratio == '0,
          tag, {coreRst, refEn, convEn, rampStart, ready}, 5'b10000);
  endtask

  task automatic stopClocks(input string tag);
    mRun = 0; fRun = 0;
    waitCycles(TIMEOUT + 20);
    checkOff(tag);
  endtask

  task automatic runCase(input int r, input int settle, input int expR, input bit expValid);
    int limit;
    bit seen;
    int n;
    limit = 32 * r + 3000;
    fHalf = 2 * r;
    settleCycles = SETTLE_W'(settle);
    mRun = 1; fRun = 1;
    seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (refEn) seen = 1;
    end
    if (expValid) begin
      check(seen, "R3 refEn reached", int'(seen), 1);
      if (seen) begin
        check(ratio == RATIO_W'(expR), "R3 rounded ratio", int'(ratio), expR);
        check(convEn == 1'b0 && coreRst == 1'b1, "R5 ref before conv", int'(convEn), 0);
        n = 0;
        while (!convEn && n < settle + 50) begin
          @(negedge clk);
          n++;
        end
        check(n == settle + 1, "R5 settle gap", n, settle + 1);
        check(rampStart == 1'b1, "R6 ramp with conv", int'(rampStart), 1);
        check(coreRst == 1'b0, "R5 core reset released", int'(coreRst), 0);
        @(negedge clk);
        check(rampStart == 1'b0 && ready == 1'b1, "R6 ready after ramp",
              {rampStart, ready}, 2'b01);
        waitCycles(100);
        check(ready == 1'b1 && refEn == 1'b1, "R6 ready held", int'(ready), 1);
      end
    end else begin
      check(!seen, "R4 no enable on bad ratio", int'(seen), 0);
      check(coreRst == 1'b1 && ratio == '0, "R4 still measuring", int'(ratio), 0);
    end
  endtask

  initial begin
    // R1: reset state
    waitCycles(3);
    checkOff("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOff("R1 after release");

    // R2: only one clock running
    fHalf = 512; mRun = 1; fRun = 0;
    waitCycles(3000);
    check(refEn == 1'b0 && coreRst == 1'b1, "R2 master only", int'(refEn), 0);
    stopClocks("R7 after master-only");
    mRun = 0; fRun = 1;
    waitCycles(3000);
    check(refEn == 1'b0 && coreRst == 1'b1, "R2 frame only", int'(refEn), 0);
    stopClocks("R7 after frame-only");

    // table of ratios and settle delays
    for (int v = 0; v < NVEC; v++) begin
      runCase(VEC_RATIO[v], VEC_SETTLE[v], VEC_EXP[v], 1'b1);
      stopClocks("R7 both clocks stopped");
    end

    // R4: ratio between supported values
    runCase(320, 3, 0, 1'b0);
    stopClocks("R7 after bad ratio");

    // R7: lose only the master clock while powered
    runCase(256, 2, 256, 1'b1);
    mRun = 0;
    waitCycles(TIMEOUT + 20);
    checkOff("R7 master lost while on");
    fRun = 0;
    waitCycles(TIMEOUT + 20);

    // R8: asynchronous reset while powered
    runCase(128, 4, 128, 1'b1);
    rstN = 1'b0;
    #1;
    checkOff("R8 immediate reset");
    waitCycles(5);
    checkOff("R8 held in reset");
    mRun = 0; fRun = 0;
    rstN = 1'b1;
    waitCycles(10);
    checkOff("R1 after second release");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule